// File: doc/BRIEF.md
# Strap-Addressed Two-Wire Register Slave

This block is a slave on a two-wire serial bus (SCL clock, SDA data). It gives a bus host access to a small bank of 8-bit registers through an internal index pointer. Both bus lines are brought into the system clock domain and oversampled there. The block finds start and stop conditions and compares the first byte of each transfer against its own 7-bit bus address. It acknowledges a match, then moves data most significant bit first. SDA is never driven high. The block only asks the pad to pull the line low.

The bus address comes from two strap inputs that are captured while reset is held. With the enable strap high, the address is 0x2C or 0x2D, as the select strap gives. With the enable strap low, a parameter gives the address. In a write transfer, the first data byte sets the pointer and an optional second byte updates the register it selects. In a read transfer, the host fetches one byte, the register at the pointer.

Top module: `strap_i2c_regslave`

## Requirements
- R1: While reset is active and after it releases, `sda_pull_o` is 0 and every register holds 0x00.
- R2: With `strap_en_i` high at reset release, the bus address is 0x2C when `strap_sel_i` is 0 and 0x2D when it is 1. Strap changes after reset release have no effect.
- R3: With `strap_en_i` low at reset release, the bus address is the parameter `DEF_ADDR` (0x2E by default).
- R4: After a start, the block takes 8 bits MSB first: 7 address bits, then the direction bit (0 = write, 1 = read). On a match it pulls SDA low for the SCL low and high phases of the ninth clock.
- R5: On an address mismatch the block never pulls SDA and ignores the bus until the next start. Registers and pointer do not change.
- R6: In a write, the first data byte is acknowledged and loaded into the pointer. A second data byte is acknowledged and written into the register the pointer selects. A write of one data byte changes no register.
- R7: A third or later data byte in a write is not acknowledged and writes nothing.
- R8: In a read, the block sends the register at the pointer MSB first, one bit per SCL clock. It then releases SDA for the host's acknowledge bit and stays released until the next start.
- R9: The register index is the low log2(`NREG`) bits of the pointer. With 16 registers, pointer 0x13 selects register 3.
- R10: A stop condition at any point returns the block to idle with SDA released. A start at any point begins a new address phase.
- R11: The block changes its SDA pull only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst | input | 1 | Synchronous active-high reset; the straps are captured while it is high |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| strap_sel_i | input | 1 | Address select strap, gives the address LSB when strapping is enabled |
| strap_en_i | input | 1 | Address strap enable; low selects the parameter address |
| sda_pull_o | output | 1 | 1 = pull SDA low; 0 = release the line |

## Verification
A pad edge reaches the protocol state three system clocks later: two synchronizer flops, then the edge register. The SDA pull follows the state with no further delay, so an acknowledge or data bit appears three clocks after the SCL falling edge that starts its slot. A register write lands on the clock that ends the eighth data bit. The bench holds each SCL phase for eight clocks and samples the line in the middle of the high phase. That is twelve clocks after the fall, well past the three-clock latency. It changes SDA only in the middle of the low phase, so every check reads a settled value.

// File: rtl/smbs_pkg.sv
package smbs_pkg;

    // high six bits of the strapped address; the select strap supplies bit 0
    localparam logic [5:0] STRAP_BASE = 6'b010110;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_AACK,
        ST_WDAT,
        ST_WACK,
        ST_RDAT,
        ST_RACK
    } phase_t;

    typedef struct packed {
        logic scl;
        logic sda;
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } line_t;

    function automatic logic [6:0] pick_addr(input logic en, input logic sel,
                                             input logic [6:0] dflt);
        return en ? {STRAP_BASE, sel} : dflt;
    endfunction

endpackage

// File: rtl/smbs_line_sync.sv
module smbs_line_sync
    import smbs_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  scl_i,
    input  logic  sda_i,
    output line_t ln
);
    logic [1:0] scl_ff;
    logic [1:0] sda_ff;
    logic       scl_d;
    logic       sda_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_ff <= 2'b11;
            sda_ff <= 2'b11;
            scl_d  <= 1'b1;
            sda_d  <= 1'b1;
        end else begin
            scl_ff <= {scl_ff[0], scl_i};
            sda_ff <= {sda_ff[0], sda_i};
            scl_d  <= scl_ff[1];
            sda_d  <= sda_ff[1];
        end
    end

    always_comb begin
        ln.scl      = scl_ff[1];
        ln.sda      = sda_ff[1];
        ln.scl_rise = scl_ff[1] & ~scl_d;
        ln.scl_fall = ~scl_ff[1] & scl_d;
        ln.start    = scl_ff[1] & scl_d & sda_d & ~sda_ff[1];
        ln.stop     = scl_ff[1] & scl_d & ~sda_d & sda_ff[1];
    end
endmodule

// File: rtl/smbs_regbank.sv
module smbs_regbank #(
    parameter int NREG  = 16,
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] idx,
    input  logic [7:0]       wr_data,
    output logic [7:0]       rd_data
);
    logic [7:0] mem [NREG];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NREG; i++) mem[i] <= 8'h00;
        end else if (wr_en) begin
            mem[idx] <= wr_data;
        end
    end

    assign rd_data = mem[idx];
endmodule

// File: rtl/smbs_engine.sv
module smbs_engine
    import smbs_pkg::*;
#(
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  line_t            ln,
    input  logic [6:0]       own_addr,
    input  logic [7:0]       rd_data,
    output logic [IDX_W-1:0] ptr,
    output logic             wr_en,
    output logic [7:0]       wr_data,
    output logic             sda_pull
);
    phase_t           st;
    logic [7:0]       sh;
    logic [3:0]       bits;
    logic [1:0]       nbytes;
    logic             is_rd;
    logic [IDX_W-1:0] ptr_q;

    wire byte_done = ln.scl_fall && (bits == 4'd8);

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_IDLE;
            sh     <= 8'h00;
            bits   <= 4'd0;
            nbytes <= 2'd0;
            is_rd  <= 1'b0;
            ptr_q  <= '0;
        end else if (ln.stop) begin
            st <= ST_IDLE;
        end else if (ln.start) begin
            st   <= ST_ADDR;
            bits <= 4'd0;
        end else begin
            case (st)
                ST_ADDR: begin
                    if (ln.scl_rise) begin
                        sh   <= {sh[6:0], ln.sda};
                        bits <= bits + 4'd1;
                    end else if (byte_done) begin
                        if (sh[7:1] == own_addr) begin
                            st    <= ST_AACK;
                            is_rd <= sh[0];
                        end else begin
                            st <= ST_IDLE;
                        end
                    end
                end
                ST_AACK: begin
                    if (ln.scl_fall) begin
                        bits   <= 4'd0;
                        nbytes <= 2'd0;
                        if (is_rd) begin
                            st <= ST_RDAT;
                            sh <= rd_data;
                        end else begin
                            st <= ST_WDAT;
                        end
                    end
                end
                ST_WDAT: begin
                    if (ln.scl_rise) begin
                        sh   <= {sh[6:0], ln.sda};
                        bits <= bits + 4'd1;
                    end else if (byte_done) begin
                        if (nbytes < 2'd2) begin
                            st     <= ST_WACK;
                            nbytes <= nbytes + 2'd1;
                            if (nbytes == 2'd0) ptr_q <= sh[IDX_W-1:0];
                        end else begin
                            st <= ST_IDLE;
                        end
                    end
                end
                ST_WACK: begin
                    if (ln.scl_fall) begin
                        bits <= 4'd0;
                        st   <= ST_WDAT;
                    end
                end
                ST_RDAT: begin
                    if (ln.scl_rise) begin
                        bits <= bits + 4'd1;
                    end else if (byte_done) begin
                        st <= ST_RACK;
                    end else if (ln.scl_fall) begin
                        sh <= {sh[6:0], 1'b0};
                    end
                end
                ST_RACK: begin
                    if (ln.scl_rise) st <= ST_IDLE;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign wr_en    = (st == ST_WDAT) && byte_done && (nbytes == 2'd1)
                      && !ln.stop && !ln.start;
    assign wr_data  = sh;
    assign ptr      = ptr_q;
    assign sda_pull = (st == ST_AACK) || (st == ST_WACK)
                      || ((st == ST_RDAT) && !sh[7]);

    // acknowledge slot only follows a complete eight-bit address byte
    assert_ack_after_byte_R4: assert property (@(posedge clk) disable iff (rst)
        (st == ST_AACK && $past(st) != ST_AACK) |-> ($past(bits) == 4'd8 && $past(ln.scl_fall)));

    // a byte never holds more than eight data clocks
    assert_bit_bound_R4: assert property (@(posedge clk) disable iff (rst)
        bits <= 4'd8);

    // the pull toggles only while the synchronized clock is low
    assert_pull_scl_low_R11: assert property (@(posedge clk) disable iff (rst)
        !$stable(sda_pull) |-> !ln.scl);
endmodule

// File: rtl/strap_i2c_regslave.sv
module strap_i2c_regslave
    import smbs_pkg::*;
#(
    parameter int         NREG     = 16,
    parameter logic [6:0] DEF_ADDR = 7'h2E
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_i,
    input  logic sda_i,
    input  logic strap_sel_i,
    input  logic strap_en_i,
    output logic sda_pull_o
);
    localparam int IDX_W = (NREG > 1) ? $clog2(NREG) : 1;

    line_t            ln;
    logic [6:0]       own_addr;
    logic [IDX_W-1:0] ptr;
    logic             wr_en;
    logic [7:0]       wr_data;
    logic [7:0]       rd_data;

    // straps follow the pins while reset is held, frozen once it releases
    always_ff @(posedge clk) begin
        if (rst) own_addr <= pick_addr(strap_en_i, strap_sel_i, DEF_ADDR);
    end

    smbs_line_sync u_sync (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .ln    (ln)
    );

    smbs_engine #(.IDX_W(IDX_W)) u_engine (
        .clk      (clk),
        .rst      (rst),
        .ln       (ln),
        .own_addr (own_addr),
        .rd_data  (rd_data),
        .ptr      (ptr),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .sda_pull (sda_pull_o)
    );

    smbs_regbank #(.NREG(NREG), .IDX_W(IDX_W)) u_bank (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .idx     (ptr),
        .wr_data (wr_data),
        .rd_data (rd_data)
    );

    assert_addr_frozen_R2: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> $stable(own_addr));

    assert_stop_release_R10: assert property (@(posedge clk) disable iff (rst)
        ln.stop |=> !sda_pull_o);
endmodule

// File: tb/strap_i2c_regslave_tb_top.sv
module strap_i2c_regslave_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int Q = 4;

    typedef struct packed {
        logic [7:0] ptr;
        logic [7:0] data;
    } vec_t;

    localparam vec_t VEC [6] = '{
        '{8'h00, 8'hA5},
        '{8'h01, 8'h5A},
        '{8'h0F, 8'h3C},
        '{8'h07, 8'hFF},
        '{8'h08, 8'h00},
        '{8'h0E, 8'h81}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl = 1'b1;
    logic m_sda = 1'b1;
    logic strap_sel = 1'b1;
    logic strap_en = 1'b1;
    logic sda_pull;
    wire  bus_sda = m_sda & ~sda_pull;

    int checks = 0;
    int errors = 0;
    int r11_viol = 0;
    logic pull_seen = 1'b0;
    logic prev_pull = 1'b0;
    logic done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    strap_i2c_regslave dut_i (
        .clk         (clk),
        .rst         (rst),
        .scl_i       (scl),
        .sda_i       (bus_sda),
        .strap_sel_i (strap_sel),
        .strap_en_i  (strap_en),
        .sda_pull_o  (sda_pull)
    );

    always @(negedge clk) begin
        if (sda_pull) pull_seen <= 1'b1;
        if (sda_pull != prev_pull && scl) r11_viol <= r11_viol + 1;
        prev_pull <= sda_pull;
    end

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic half();
        repeat (Q) @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        scl = 1'b1;
        m_sda = 1'b1;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic bit_out(input logic b, output logic seen);
        half(); m_sda = b;
        half(); scl = 1'b1;
        half(); seen = bus_sda;
        half(); scl = 1'b0;
    endtask

    task automatic bus_start();
        m_sda = 1'b1; scl = 1'b1;
        half(); m_sda = 1'b0;
        half(); scl = 1'b0;
    endtask

    task automatic bus_stop();
        half(); m_sda = 1'b0;
        half(); scl = 1'b1;
        half(); m_sda = 1'b1;
        half(); half();
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        logic s;
        for (int i = 7; i >= 0; i--) bit_out(b[i], s);
        bit_out(1'b1, s);
        ack = !s;
    endtask

    task automatic recv_byte(output logic [7:0] d);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            bit_out(1'b1, s);
            d[i] = s;
        end
        bit_out(1'b1, s);
    endtask

    task automatic wr(input logic [6:0] a, input logic [7:0] p, input logic two,
                      input logic [7:0] d, output logic ka, output logic kp, output logic kd);
        bus_start();
        send_byte({a, 1'b0}, ka);
        send_byte(p, kp);
        kd = 1'b0;
        if (two) send_byte(d, kd);
        bus_stop();
    endtask

    task automatic rd(input logic [6:0] a, output logic ka, output logic [7:0] d);
        bus_start();
        send_byte({a, 1'b1}, ka);
        recv_byte(d);
        bus_stop();
    endtask

    task automatic read_reg(input logic [6:0] a, input logic [7:0] p, output logic [7:0] d);
        logic ka, kp, kd;
        wr(a, p, 1'b0, 8'h00, ka, kp, kd);
        rd(a, ka, d);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic ka, kp, kd;
        logic [7:0] d;

        // R1: reset state
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 pull during reset", {7'd0, sda_pull}, 8'h00);
        do_reset();
        check("R1 pull after reset", {7'd0, sda_pull}, 8'h00);
        strap_sel = 1'b0; // R2: change after release must not matter
        read_reg(7'h2D, 8'h05, d);
        check("R1 register reset value", d, 8'h00);

        // R6 R9: vector table, writes then readback through pointer-only writes
        foreach (VEC[i]) begin
            wr(7'h2D, VEC[i].ptr, 1'b1, VEC[i].data, ka, kp, kd);
            check("R4 address ack", {7'd0, ka}, 8'h01);
            check("R6 pointer byte ack", {7'd0, kp}, 8'h01);
            check("R6 data byte ack", {7'd0, kd}, 8'h01);
        end
        foreach (VEC[i]) begin
            read_reg(7'h2D, VEC[i].ptr, d);
            check("R8 readback", d, VEC[i].data);
            check("R8 release after read", {7'd0, sda_pull}, 8'h00);
        end

        // R2 R5: other strap address is ignored, bus stays untouched
        pull_seen = 1'b0;
        @(negedge clk) pull_seen = 1'b0;
        wr(7'h2C, 8'h01, 1'b1, 8'hEE, ka, kp, kd);
        check("R5 no address ack", {7'd0, ka}, 8'h00);
        check("R5 no pull at all", {7'd0, pull_seen}, 8'h00);
        read_reg(7'h2D, 8'h01, d);
        check("R5 register untouched", d, 8'h5A);

        // R7: third data byte
        bus_start();
        send_byte({7'h2D, 1'b0}, ka);
        send_byte(8'h02, kp);
        send_byte(8'h11, kd);
        check("R7 second byte ack", {7'd0, kd}, 8'h01);
        send_byte(8'h99, kd);
        check("R7 third byte no ack", {7'd0, kd}, 8'h00);
        bus_stop();
        read_reg(7'h2D, 8'h02, d);
        check("R7 register keeps second byte", d, 8'h11);

        // R9: pointer aliasing on the low index bits
        wr(7'h2D, 8'h13, 1'b1, 8'h77, ka, kp, kd);
        read_reg(7'h2D, 8'h03, d);
        check("R9 pointer 0x13 hits register 3", d, 8'h77);

        // R6: one-byte write leaves register alone
        wr(7'h2D, 8'h03, 1'b0, 8'h00, ka, kp, kd);
        rd(7'h2D, ka, d);
        check("R6 pointer-only write keeps data", d, 8'h77);

        // R10: stop in the middle of the address byte
        bus_start();
        bit_out(1'b0, kd);
        bit_out(1'b1, kd);
        bit_out(1'b0, kd);
        bus_stop();
        check("R10 released after stop", {7'd0, sda_pull}, 8'h00);
        rd(7'h2D, ka, d);
        check("R10 recovers after abort ack", {7'd0, ka}, 8'h01);
        check("R10 recovers after abort data", d, 8'h77);

        // R3: strapping disabled selects the parameter address
        strap_en = 1'b0;
        do_reset();
        rd(7'h2D, ka, d);
        check("R3 strap address rejected", {7'd0, ka}, 8'h00);
        read_reg(7'h2E, 8'h00, d);
        check("R3 default address reads reset value", d, 8'h00);
        wr(7'h2E, 8'h04, 1'b1, 8'hC3, ka, kp, kd);
        check("R3 default address ack", {7'd0, ka}, 8'h01);
        read_reg(7'h2E, 8'h04, d);
        check("R3 default address readback", d, 8'hC3);

        // R2: strap select low gives 0x2C
        strap_en = 1'b1;
        strap_sel = 1'b0;
        do_reset();
        strap_sel = 1'b1;
        wr(7'h2C, 8'h06, 1'b1, 8'h42, ka, kp, kd);
        check("R2 address 0x2C ack", {7'd0, ka}, 8'h01);
        rd(7'h2D, ka, d);
        check("R2 address 0x2D rejected", {7'd0, ka}, 8'h00);
        read_reg(7'h2C, 8'h06, d);
        check("R2 address 0x2C readback", d, 8'h42);

        check("R11 pull changes with SCL high", r11_viol[7:0], 8'h00);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule